// File: doc/BRIEF.md
# Character-LCD Power-Up Sequencer with Subroutine Stack

This block is a hardware controller that brings a character LCD with a 4-bit data path out of power-up. It needs no soft processor. It sends the usual power-up sequence: three `0x3` wake-up nibbles with shrinking pauses, a `0x2` nibble that selects 4-bit mode, and four byte commands. Each byte command goes out as two nibbles, high nibble first. The four commands are function set `0x28`, entry mode `0x06`, display on `0x0C` and clear `0x01`.

Two state sequences are needed many times: a timed pause, and a nibble write that strobes the enable line. Each is written only once, as a subroutine. To call one, the controller pushes the state it should continue at onto a small return stack and then jumps to the first state of the subroutine. The last state of the subroutine pops that entry and jumps to it. The nibble-write subroutine calls the pause subroutine itself, so calls nest two levels deep.

A parameter chooses how the stack is built. In flip-flops, a return takes one cycle. In inferable RAM, the popped word is read through a register, so each return costs one extra cycle.

Top module: `lcd_init_sequencer`

## Requirements
- R1: A synchronous active-high reset drives `lcd_en`, `init_done` and `stack_err` low and restarts the controller at the power-on pause.
- R2: After reset is released, the first `lcd_en` rise comes at clock edge `PWR_DLY+3` in flip-flop stack mode, and one edge later in RAM stack mode.
- R3: Twelve nibble writes go out in this order on `lcd_data`: 3, 3, 3, 2, 2, 8, 0, 6, 0, C, 0, 1. `lcd_rs` is 0 for all of them, and `lcd_data` stays stable while `lcd_en` is high.
- R4: Each write holds `lcd_en` high for exactly `EN_CYCLES` cycles.
- R5: In flip-flop mode, `lcd_en` stays low for the write's post-delay plus 3 cycles after each write. The post-delays are `DLY1`, `DLY2` and `DLY3` for the wake-up nibbles, `CLR_DLY` for the last nibble, and `CMD_DLY` for every other nibble.
- R6: `init_done` rises `CLR_DLY+3` cycles after the last `lcd_en` fall (flip-flop mode) and then stays high until reset.
- R7: When `init_done` is high, the return stack is empty and `stack_err` is low.
- R8: In RAM stack mode, each of the 25 returns in the run costs one extra cycle, so `init_done` rises exactly 25 cycles later than in flip-flop mode.
- R9: A push to a full stack, or a pop from an empty one, leaves the stack pointer unchanged and sets `stack_err`, which stays set until reset. With a depth of 1, the nested call overflows and `stack_err` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lcd_data | output | 4 | Data nibble to the display |
| lcd_rs | output | 1 | Register select (0 = command) |
| lcd_en | output | 1 | Enable strobe |
| init_done | output | 1 | Sticky completion flag |
| stack_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench measures every enable pulse width and every low gap, and compares them with a vector table. This catches a subroutine that returns one cycle early or late, and a pause that skips its zero count. A stack that popped the wrong entry would show up as nibbles out of order or a sequence that never ends. The bench runs the RAM-style stack beside the flip-flop stack and checks that completion comes exactly 25 cycles later; a RAM read that was not registered, or a return that skipped its wait state, would break that difference. A depth-1 instance must raise the sticky error flag when the nested call is made. A stack that wrapped its pointer instead would corrupt the sequence.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [3:0] {
    S_PWR     = 4'd0,
    S_INIT1   = 4'd1,
    S_INIT2   = 4'd2,
    S_INIT3   = 4'd3,
    S_MODE4   = 4'd4,
    S_CMD_HI  = 4'd5,
    S_CMD_LO  = 4'd6,
    S_WR_EN   = 4'd7,
    S_WR_RET  = 4'd8,
    S_WAIT    = 4'd9,
    S_RETURN  = 4'd10,
    S_DONE    = 4'd11
  } seq_state_t;

  localparam int STATE_W = 4;
  localparam int NUM_CMDS = 4;

  function automatic logic [7:0] cmd_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    cmd_byte = 8'h28;
      2'd1:    cmd_byte = 8'h06;
      2'd2:    cmd_byte = 8'h0C;
      default: cmd_byte = 8'h01;
    endcase
  endfunction
endpackage

// File: rtl/down_counter.sv
module down_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (load)
      cnt <= load_val;
    else if (dec && cnt != '0)
      cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH     = 4,
  parameter int W         = 4,
  parameter bit RAM_STYLE = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               top,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       err
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] sp;
  logic          err_q;
  logic          full, empty;
  logic [AW-1:0] wr_addr, rd_addr;

  assign full    = (sp == PW'(DEPTH));
  assign empty   = (sp == '0);
  assign wr_addr = AW'(sp);
  assign rd_addr = AW'(sp - PW'(1));

  always_ff @(posedge clk) begin
    if (push && !full)
      mem[wr_addr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp    <= '0;
      err_q <= 1'b0;
    end else if (push) begin
      if (full) err_q <= 1'b1;
      else      sp    <= sp + PW'(1);
    end else if (pop) begin
      if (empty) err_q <= 1'b1;
      else       sp    <= sp - PW'(1);
    end
  end

  generate
    if (RAM_STYLE) begin : g_ram
      logic [W-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= mem[rd_addr];
      assign top = rd_q;
    end else begin : g_reg
      assign top = mem[rd_addr];
    end
  endgenerate

  assign level = sp;
  assign err   = err_q;

  // R9
  full_push_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ($stable(sp) && err_q));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> ($stable(sp) && err_q));
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sp <= PW'(DEPTH));
endmodule

// File: rtl/lcd_init_sequencer.sv
module lcd_init_sequencer
  import seq_pkg::*;
#(
  parameter int STACK_DEPTH   = 4,
  parameter bit USE_RAM_STACK = 1'b0,
  parameter int DELAY_W       = 20,
  parameter int EN_CYCLES     = 12,
  parameter int PWR_DLY       = 750000,
  parameter int DLY1          = 205000,
  parameter int DLY2          = 5000,
  parameter int DLY3          = 2000,
  parameter int CMD_DLY       = 2000,
  parameter int CLR_DLY       = 82000
) (
  input  logic       clk,
  input  logic       rst,
  output logic [3:0] lcd_data,
  output logic       lcd_rs,
  output logic       lcd_en,
  output logic       init_done,
  output logic       stack_err
);
  localparam int EW = (EN_CYCLES > 1) ? $clog2(EN_CYCLES) : 1;
  localparam int LW = $clog2(STACK_DEPTH + 1);

  seq_state_t state, nxt, ret_tgt;
  logic [STATE_W-1:0] top_w, push_val;
  logic [LW-1:0]      stk_level;
  logic               push, pop;
  logic               dly_ld, dly_dec, dly_zero;
  logic [DELAY_W-1:0] dly_val;
  logic               en_ld, en_dec, en_zero;
  logic               wr_start, e_clr, idx_inc;
  logic [3:0]         wr_nib;
  logic [1:0]         cmd_idx;
  logic [7:0]         cmd;
  logic               last_cmd;

  ret_stack #(.DEPTH(STACK_DEPTH), .W(STATE_W), .RAM_STYLE(USE_RAM_STACK)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(push_val),
    .top(top_w), .level(stk_level), .err(stack_err)
  );

  down_counter #(.W(DELAY_W)) u_delay (
    .clk(clk), .load(dly_ld), .load_val(dly_val), .dec(dly_dec), .zero(dly_zero)
  );

  down_counter #(.W(EW)) u_en (
    .clk(clk), .load(en_ld), .load_val(EW'(EN_CYCLES - 1)), .dec(en_dec), .zero(en_zero)
  );

  assign cmd      = cmd_byte(cmd_idx);
  assign last_cmd = (cmd_idx == 2'(NUM_CMDS - 1));
  assign ret_tgt  = USE_RAM_STACK ? S_RETURN : seq_state_t'(top_w);

  always_comb begin
    nxt = state; push = 1'b0; push_val = STATE_W'(S_PWR); pop = 1'b0;
    dly_ld = 1'b0; dly_val = '0; dly_dec = 1'b0; en_dec = 1'b0;
    wr_start = 1'b0; wr_nib = 4'h0; e_clr = 1'b0; idx_inc = 1'b0;
    case (state)
      S_PWR: begin
        dly_ld = 1'b1; dly_val = DELAY_W'(PWR_DLY);
        push = 1'b1; push_val = STATE_W'(S_INIT1); nxt = S_WAIT;
      end
      S_INIT1: begin
        wr_start = 1'b1; wr_nib = 4'h3; dly_val = DELAY_W'(DLY1);
        push_val = STATE_W'(S_INIT2);
      end
      S_INIT2: begin
        wr_start = 1'b1; wr_nib = 4'h3; dly_val = DELAY_W'(DLY2);
        push_val = STATE_W'(S_INIT3);
      end
      S_INIT3: begin
        wr_start = 1'b1; wr_nib = 4'h3; dly_val = DELAY_W'(DLY3);
        push_val = STATE_W'(S_MODE4);
      end
      S_MODE4: begin
        wr_start = 1'b1; wr_nib = 4'h2; dly_val = DELAY_W'(CMD_DLY);
        push_val = STATE_W'(S_CMD_HI);
      end
      S_CMD_HI: begin
        wr_start = 1'b1; wr_nib = cmd[7:4]; dly_val = DELAY_W'(CMD_DLY);
        push_val = STATE_W'(S_CMD_LO);
      end
      S_CMD_LO: begin
        wr_start = 1'b1; wr_nib = cmd[3:0]; idx_inc = 1'b1;
        dly_val  = last_cmd ? DELAY_W'(CLR_DLY) : DELAY_W'(CMD_DLY);
        push_val = last_cmd ? STATE_W'(S_DONE) : STATE_W'(S_CMD_HI);
      end
      S_WR_EN: begin
        if (en_zero) begin
          e_clr = 1'b1; push = 1'b1; push_val = STATE_W'(S_WR_RET); nxt = S_WAIT;
        end else begin
          en_dec = 1'b1;
        end
      end
      S_WAIT: begin
        if (dly_zero) begin
          pop = 1'b1; nxt = ret_tgt;
        end else begin
          dly_dec = 1'b1;
        end
      end
      S_WR_RET: begin
        pop = 1'b1; nxt = ret_tgt;
      end
      S_RETURN: nxt = seq_state_t'(top_w);
      S_DONE:   nxt = S_DONE;
      default:  nxt = S_PWR;
    endcase
    if (wr_start) begin
      push = 1'b1; dly_ld = 1'b1; nxt = S_WR_EN;
    end
  end

  assign en_ld = wr_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_PWR;
      lcd_en    <= 1'b0;
      lcd_data  <= 4'h0;
      lcd_rs    <= 1'b0;
      cmd_idx   <= 2'd0;
      init_done <= 1'b0;
    end else begin
      state <= nxt;
      if (wr_start) begin
        lcd_en   <= 1'b1;
        lcd_data <= wr_nib;
        lcd_rs   <= 1'b0;
      end
      if (e_clr)   lcd_en  <= 1'b0;
      if (idx_inc) cmd_idx <= cmd_idx + 2'd1;
      if (state == S_DONE) init_done <= 1'b1;
    end
  end

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  // R7
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (stk_level == '0));
  // R4
  en_state_chk: assert property (@(posedge clk) disable iff (rst)
    lcd_en |-> (state == S_WR_EN));
  // R3
  data_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (lcd_en && $past(lcd_en)) |-> $stable(lcd_data));
endmodule

// File: tb/sim_lcd_init_sequencer.sv
`timescale 1ns/1ps
module sim_lcd_init_sequencer;
  localparam int EN  = 2;
  localparam int PWR = 20;
  localparam int D1  = 10;
  localparam int D2  = 6;
  localparam int D3  = 4;
  localparam int CMD = 3;
  localparam int CLR = 8;
  localparam int NV  = 12;
  localparam int NUM_RETURNS = 25;

  localparam logic [3:0] VNIB [NV] = '{4'h3, 4'h3, 4'h3, 4'h2, 4'h2, 4'h8,
                                      4'h0, 4'h6, 4'h0, 4'hC, 4'h0, 4'h1};
  localparam int VDLY [NV] = '{D1, D2, D3, CMD, CMD, CMD, CMD, CMD, CMD, CMD, CMD, CLR};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0] d0, d1, d2;
  logic rs0, rs1, rs2, e0, e1, e2, dn0, dn1, dn2, er0, er1, er2;

  lcd_init_sequencer #(.STACK_DEPTH(4), .USE_RAM_STACK(1'b0), .DELAY_W(8), .EN_CYCLES(EN),
    .PWR_DLY(PWR), .DLY1(D1), .DLY2(D2), .DLY3(D3), .CMD_DLY(CMD), .CLR_DLY(CLR)) u0 (
    .clk(clk), .rst(rst), .lcd_data(d0), .lcd_rs(rs0), .lcd_en(e0),
    .init_done(dn0), .stack_err(er0));

  lcd_init_sequencer #(.STACK_DEPTH(4), .USE_RAM_STACK(1'b1), .DELAY_W(8), .EN_CYCLES(EN),
    .PWR_DLY(PWR), .DLY1(D1), .DLY2(D2), .DLY3(D3), .CMD_DLY(CMD), .CLR_DLY(CLR)) u1 (
    .clk(clk), .rst(rst), .lcd_data(d1), .lcd_rs(rs1), .lcd_en(e1),
    .init_done(dn1), .stack_err(er1));

  lcd_init_sequencer #(.STACK_DEPTH(1), .USE_RAM_STACK(1'b0), .DELAY_W(8), .EN_CYCLES(EN),
    .PWR_DLY(PWR), .DLY1(D1), .DLY2(D2), .DLY3(D3), .CMD_DLY(CMD), .CLR_DLY(CLR)) u2 (
    .clk(clk), .rst(rst), .lcd_data(d2), .lcd_rs(rs2), .lcd_en(e2),
    .init_done(dn2), .stack_err(er2));

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int t0 = -1;
  int t1 = -1;
  int t_e1 = -1;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst) begin
      t0 <= -1; t1 <= -1; t_e1 <= -1;
    end else begin
      if (dn0 && t0 < 0) t0 <= cyc;
      if (dn1 && t1 < 0) t1 <= cyc;
      if (e1 && t_e1 < 0) t_e1 <= cyc;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int n;
    int rise0;
    int hi;
    int lo;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!e0 && !e1 && !e2, "R1 enable low in reset", int'(e0 | e1 | e2), 0);
    check(!dn0 && !dn1 && !dn2, "R1 done low in reset", int'(dn0 | dn1 | dn2), 0);
    check(!er0 && !er1 && !er2, "R1 err low in reset", int'(er0 | er1 | er2), 0);
    rst = 1'b0;
    rise0 = cyc;

    // R2: power-on pause length
    n = 0;
    while (!e0 && n < 1000) begin step(); n++; end
    check(n == PWR + 3, "R2 first enable edge", n, PWR + 3);

    for (int i = 0; i < NV; i++) begin
      // R3: nibble order and register select
      check(d0 == VNIB[i], "R3 nibble value", int'(d0), int'(VNIB[i]));
      check(rs0 == 1'b0, "R3 register select", int'(rs0), 0);
      // R4: enable pulse width
      hi = 0;
      while (e0 && hi < 1000) begin step(); hi++; end
      check(hi == EN, "R4 enable width", hi, EN);
      lo = 0;
      while (!e0 && !dn0 && lo < 1000) begin step(); lo++; end
      if (i < NV - 1) begin
        // R5: post-delay gap
        check(lo == VDLY[i] + 3 && !dn0, "R5 gap after write", lo, VDLY[i] + 3);
      end else begin
        // R6: done timing after the final write
        check(dn0 && lo == CLR + 3, "R6 done timing", lo, CLR + 3);
      end
    end

    repeat (10) step();
    // R6: done stays high
    check(dn0, "R6 done sticky", int'(dn0), 1);
    // R7: clean completion, no stack error
    check(!er0, "R7 no stack error", int'(er0), 0);

    n = 0;
    while ((!dn1 || !dn2) && n < 2000) begin step(); n++; end
    step();
    // R8: RAM stack costs one cycle per return
    check(t1 - t0 == NUM_RETURNS, "R8 RAM stack completion offset", t1 - t0, NUM_RETURNS);
    check(t_e1 - rise0 == PWR + 4, "R8 RAM stack first enable", t_e1 - rise0, PWR + 4);
    check(!er1, "R7 RAM stack no error", int'(er1), 0);
    // R9: depth-1 stack overflows on the nested call, flag sticks
    check(er2, "R9 overflow flag", int'(er2), 1);
    check(dn2, "R9 overflowing instance still completes", int'(dn2), 1);

    // R1: reset in mid-life clears the sticky flags
    rst = 1'b1;
    step();
    check(!dn0 && !er2 && !e0, "R1 reset clears flags", int'(dn0 | er2 | e0), 0);
    rst = 1'b0;
    n = 0;
    while (!e0 && n < 1000) begin step(); n++; end
    // R2: power-on pause repeats after a second reset
    check(n == PWR + 3, "R2 first enable after re-reset", n, PWR + 3);
    check(d0 == 4'h3, "R3 first nibble after re-reset", int'(d0), 3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule